// File: doc/BRIEF.md
# Interval Timer with Toggle Output

This block counts ticks with an up counter and compares the count on every tick against a programmable compare value. A tick on which the counter equals the compare value is a match. On a match the counter goes back to zero, a one-cycle interrupt pulse is raised, and the output flip-flop toggles if hardware toggling is enabled. The time between matches is therefore the compare value plus one ticks.

Software reaches the block through a plain, unhandshaked register write port. It can load the compare value and set two configuration bits. It can also drive the output flip-flop directly with a 2-bit command that clears, sets or toggles it. When double buffering is on, compare writes land in a shadow register. The shadow value moves into the active compare register only at the next match, so a running period is never cut short or stretched.

The write port is a control path with no back-pressure. A write is taken on any clock edge where `wr_en` is high. The tick input and the interrupt output are plain single-cycle strobes.

Top module: `ivl_timer`

## Requirements
- R1: With compare value c, a tick that finds the counter equal to c clears the counter to 0. Any other tick adds one to the counter. Starting from 0, interrupts therefore occur every c+1 ticks, and c=0 gives one on every tick.
- R2: The counter changes only on cycles where `tick` is high. A match can only happen on such a cycle, so no interrupt is raised while `tick` is low.
- R3: `irq` is high for exactly one cycle, the cycle after the clock edge that samples the matching tick. It is low in all other cycles.
- R4: Register address 1, bit 0 is the hardware toggle enable. When it is 1, each match inverts `tff_out` at the same edge that clears the counter. When it is 0, a match leaves `tff_out` unchanged.
- R5: A write to address 2 with `wr_data[1:0]`=01 forces `tff_out` to 0, and with 10 forces it to 1.
- R6: A write to address 2 with `wr_data[1:0]`=00 inverts `tff_out`.
- R7: A write to address 2 with `wr_data[1:0]`=11 does not change `tff_out`, and it does not block a hardware toggle in the same cycle.
- R8: If a write to address 2 with a code other than 11 and a hardware toggle fall on the same edge, only the software command takes effect.
- R9: Register address 1, bit 1 is the double-buffer enable. When it is 1, a write to address 0 goes to the shadow register only, and the active compare value is loaded from the shadow at the next match.
- R10: When the double-buffer enable is 0, a write to address 0 changes the active compare value on the next edge.
- R11: Reset clears the counter, the active and shadow compare registers, both configuration bits, `irq` and `tff_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 compare, 1 config, 2 flip-flop command |
| wr_data | input | 8 | Write data |
| irq | output | 1 | One-cycle interrupt pulse on match |
| tff_out | output | 1 | Output flip-flop |

## Verification
Long continuous tick bursts are run with several compare values, including 0 and the maximum, and with the toggle enable on and off. The interrupt count and the final flip-flop level separate an off-by-one period from a correct one, and enabled toggling from disabled toggling. Gapped tick patterns with long idle stretches show whether the counter holds its value between ticks. A compare write placed in the middle of a period gives a different interrupt position for immediate update than for buffered update. Flip-flop commands are also issued on the same edge as a match, which exposes the wrong priority and the wrong handling of code 11.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  typedef enum logic [1:0] {
    FF_TOGGLE = 2'b00,
    FF_CLEAR  = 2'b01,
    FF_SET    = 2'b10,
    FF_KEEP   = 2'b11
  } ff_cmd_e;

  typedef struct packed {
    logic dbuf_en;
    logic inv_en;
  } tmr_cfg_t;
endpackage

// File: rtl/ivl_timer_creg.sv
module ivl_timer_creg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_val,
  input  logic         dbuf_en,
  input  logic         load,
  output logic [W-1:0] cmp_o
);
  logic [W-1:0] act_q, shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (wr_cmp) shadow_q <= wr_val;
      if (wr_cmp && !dbuf_en)      act_q <= wr_val;
      else if (load && dbuf_en)    act_q <= shadow_q;
    end
  end

  assign cmp_o = act_q;

  // R9
  dbuf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dbuf_en && !load) |=> $stable(act_q));
  // R9
  dbuf_load_chk: assert property (@(posedge clk) disable iff (rst)
    (dbuf_en && load) |=> (act_q == $past(shadow_q)));
  // R10
  direct_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmp && !dbuf_en) |=> (act_q == $past(wr_val)));
endmodule

// File: rtl/ivl_timer_cnt.sv
module ivl_timer_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cmp,
  output logic         match_o
);
  logic [W-1:0] cnt_q;

  assign match_o = tick && (cnt_q == cmp);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (match_o) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |=> (cnt_q == '0));
  // R1
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !match_o) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/ivl_timer_tff.sv
module ivl_timer_tff
  import ivl_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sw_wr,
  input  ff_cmd_e sw_cmd,
  input  logic    hw_tog,
  input  logic    inv_en,
  output logic    ff_o
);
  logic ff_q;
  logic sw_act;

  assign sw_act = sw_wr && (sw_cmd != FF_KEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q <= 1'b0;
    end else if (sw_act) begin
      case (sw_cmd)
        FF_CLEAR:  ff_q <= 1'b0;
        FF_SET:    ff_q <= 1'b1;
        FF_TOGGLE: ff_q <= ~ff_q;
        default:   ff_q <= ff_q;
      endcase
    end else if (hw_tog && inv_en) begin
      ff_q <= ~ff_q;
    end
  end

  assign ff_o = ff_q;

  // R5
  sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && sw_cmd == FF_CLEAR) |=> !ff_q);
  // R5
  sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && sw_cmd == FF_SET) |=> ff_q);
  // R6
  sw_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && sw_cmd == FF_TOGGLE) |=> (ff_q != $past(ff_q)));
  // R4
  hw_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_tog && inv_en && !sw_act) |=> (ff_q != $past(ff_q)));
  // R4
  hw_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_act && !(hw_tog && inv_en)) |=> $stable(ff_q));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              irq,
  output logic              tff_out
);
  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FF  = ADDR_W'(2);

  tmr_cfg_t         cfg_q;
  logic             irq_q;
  logic             match;
  logic [CNT_W-1:0] cmp_val;
  logic             wr_cmp, wr_cfg, wr_ff;

  assign wr_cmp = wr_en && (wr_addr == A_CMP);
  assign wr_cfg = wr_en && (wr_addr == A_CFG);
  assign wr_ff  = wr_en && (wr_addr == A_FF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      cfg_q.inv_en  <= wr_data[0];
      cfg_q.dbuf_en <= wr_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= match;
  end

  ivl_timer_creg #(.W(CNT_W)) u_creg (
    .clk     (clk),
    .rst     (rst),
    .wr_cmp  (wr_cmp),
    .wr_val  (wr_data),
    .dbuf_en (cfg_q.dbuf_en),
    .load    (match),
    .cmp_o   (cmp_val)
  );

  ivl_timer_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cmp     (cmp_val),
    .match_o (match)
  );

  ivl_timer_tff u_tff (
    .clk    (clk),
    .rst    (rst),
    .sw_wr  (wr_ff),
    .sw_cmd (ff_cmd_e'(wr_data[1:0])),
    .hw_tog (match),
    .inv_en (cfg_q.inv_en),
    .ff_o   (tff_out)
  );

  assign irq = irq_q;

  // R3
  irq_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> irq);
  // R3
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !match |=> !irq);
  // R2
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !irq);
endmodule

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq, tff_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ivl_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .tff_out(tff_out)
  );

  localparam int NV = 6;
  localparam int V_CMP   [NV] = '{3, 3, 0, 4, 255, 7};
  localparam int V_INV   [NV] = '{1, 1, 1, 0, 1, 1};
  localparam int V_TICKS [NV] = '{8, 12, 5, 15, 256, 7};
  localparam int V_IRQS  [NV] = '{2, 3, 5, 3, 1, 0};
  localparam int V_FF    [NV] = '{0, 1, 1, 0, 1, 0};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (irq) hits++;
    end
    tick = 1'b0;
  endtask

  task automatic tick_wr(input logic [1:0] code);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = {6'd0, code};
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h;
    @(negedge clk);
    do_reset();
    // R11 reset state
    check(irq == 1'b0, "R11 irq after reset", irq, 0);
    check(tff_out == 1'b0, "R11 tff after reset", tff_out, 0);

    // R1 R4 vector table: period and hardware toggle
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(2'd0, 8'(V_CMP[v]));
      wr(2'd1, 8'(V_INV[v]));
      pulse(V_TICKS[v], h);
      check(h == V_IRQS[v], "R1 irq count", h, V_IRQS[v]);
      check(int'(tff_out) == V_FF[v], "R4 tff after burst", tff_out, V_FF[v]);
    end

    // R5 R6 R7 software commands
    do_reset();
    wr(2'd2, 8'd2); check(tff_out == 1'b1, "R5 set", tff_out, 1);
    wr(2'd2, 8'd0); check(tff_out == 1'b0, "R6 toggle", tff_out, 0);
    wr(2'd2, 8'd0); check(tff_out == 1'b1, "R6 toggle", tff_out, 1);
    wr(2'd2, 8'd3); check(tff_out == 1'b1, "R7 keep", tff_out, 1);
    wr(2'd2, 8'd1); check(tff_out == 1'b0, "R5 clear", tff_out, 0);

    // R8 R7 R4 same-edge interaction, compare 0 so every tick matches
    do_reset();
    wr(2'd1, 8'd1);
    tick_wr(2'b01);
    check(tff_out == 1'b0, "R8 sw wins over hw", tff_out, 0);
    check(irq == 1'b1, "R3 irq with sw write", irq, 1);
    tick_wr(2'b11);
    check(tff_out == 1'b1, "R7 keep lets hw toggle", tff_out, 1);
    pulse(1, h);
    check(tff_out == 1'b0, "R4 hw toggle", tff_out, 0);
    wr(2'd1, 8'd0);
    pulse(1, h);
    check(tff_out == 1'b0, "R4 toggle disabled", tff_out, 0);
    check(h == 1, "R1 compare zero", h, 1);

    // R3 R2 pulse width and tick gating
    do_reset();
    wr(2'd0, 8'd2);
    pulse(3, h);
    check(h == 1, "R3 one pulse", h, 1);
    @(negedge clk);
    check(irq == 1'b0, "R3 single cycle", irq, 0);
    pulse(2, h);
    h = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (irq) h++;
    end
    check(h == 0, "R2 no irq while idle", h, 0);
    pulse(1, h);
    check(h == 1, "R2 count held across idle", h, 1);

    // R9 double buffer
    do_reset();
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd2);
    wr(2'd0, 8'd1);
    pulse(3, h);
    check(h == 0, "R9 old compare kept", h, 0);
    pulse(1, h);
    check(h == 1, "R9 match at old compare", h, 1);
    pulse(2, h);
    check(h == 1, "R9 new compare after boundary", h, 1);

    // R10 immediate update
    do_reset();
    wr(2'd0, 8'd5);
    pulse(2, h);
    wr(2'd0, 8'd2);
    pulse(1, h);
    check(h == 1, "R10 immediate compare", h, 1);

    // R11 reset clears configuration
    wr(2'd0, 8'd5);
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd2);
    do_reset();
    check(tff_out == 1'b0, "R11 tff cleared", tff_out, 0);
    pulse(1, h);
    check(h == 1, "R11 compare cleared", h, 1);
    check(tff_out == 1'b0, "R11 toggle enable cleared", tff_out, 0);
    wr(2'd0, 8'd3);
    pulse(3, h);
    check(h == 0, "R11 double buffer cleared", h, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule